// File: doc/BRIEF.md
# Full-frame CCD readout sequencer

This block produces the digital clock patterns that drain a full-frame CCD built with a two-phase vertical register and a two-phase horizontal register. While the exposure input is high, or while no readout has been requested, the vertical clocks rest low. The last horizontal phase rests high, ready for a row to be dropped into it.

A readout request accepted in the resting state walks the whole array. For each row, the two vertical phases are pulsed one after the other. When the second vertical phase falls, the row lands in the horizontal register while the first horizontal phase is held high. After a programmable settle time, every horizontal position is clocked out with complementary horizontal phases. This includes the column-less dummy phases at both ends of the line.

Each falling edge of the first horizontal phase moves a charge packet onto the output node. In that cycle the block raises a sample strobe and reports a region tag for that packet, so downstream logic can separate dark reference data from image data. A line marker comes with the first strobe of each row. A frame marker follows the last pixel of the last row, and the block then rests again.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset, and whenever no readout is running, `v1_o` and `v2_o` are 0, `h1_o` and `h1l_o` are 1, `h2_o` is 0, and `pix_strobe_o` is 0.
- R2: A readout begins only when `start_i` is 1 and `expose_i` is 0 at a clock edge while resting. `start_i` has no effect while `expose_i` is 1 or while a readout is in progress.
- R3: Each row transfer drives `v1_o` high for VPHASE cycles and then `v2_o` high for VPHASE cycles. The two are never high together, and `h1_o` is high whenever `v2_o` falls.
- R4: After `v2_o` falls, `h1_o` stays high for SETTLE cycles before the first horizontal shift of that row.
- R5: Each horizontal position takes 2*HALF_DIV cycles: HALF_DIV cycles with `h1_o`=0 and `h2_o`=1, then HALF_DIV cycles with `h1_o`=1 and `h2_o`=0. `h1l_o` always equals `h1_o`.
- R6: `pix_strobe_o` is 1 only in the first cycle of each low half of `h1_o`. A frame therefore yields exactly one strobe per horizontal position per row.
- R7: Columns are laid out in this order: lead dummy, lead monitor, lead dark, lead buffer, active, trail buffer, trail dark, trail monitor, trail gap, trail dummy. The default sizes are 11, 1, 20, 9, 4080, 9, 9, 1, 3 and 2, which give 4145 positions. Gap and dummy positions are tagged dummy (0). Dark is 1, buffer is 2, monitor is 3 and active is 4.
- R8: Rows are laid out in this order: lead dark (20), lead buffer (9), active (5440), trail buffer (9), monitor row (1), trail dark (9), for 5488 rows. The tag presented with each strobe is chosen by priority: a dummy column gives dummy; otherwise dark if the row or the column is dark; otherwise monitor if either is monitor; otherwise buffer if either is buffer; otherwise active.
- R9: `line_start_o` is 1 exactly in the strobe cycle of the first position of each row.
- R10: Each row's transfer begins in the cycle after the previous row's last high half ends. After the last row, `frame_end_o` is 1 for one cycle, which is the first resting cycle. A start presented in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| expose_i | input | 1 | High while the sensor integrates; blocks readout start |
| start_i | input | 1 | Readout request, sampled while resting |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| h1l_o | output | 1 | Last-stage horizontal phase 1 |
| pix_strobe_o | output | 1 | Sample strobe, one per charge packet |
| pix_region_o | output | 3 | Region tag of the strobed packet |
| line_start_o | output | 1 | First strobe of a row |
| frame_end_o | output | 1 | One-cycle pulse after the last pixel |

## Verification
The hardest situations to reach are a start request that lands in the very cycle of the frame marker, and a request made mid-frame that must be ignored. The stimulus waits on the frame marker at the falling clock edge and raises the start input during that cycle, which produces two back-to-back frames with no resting gap. The stimulus also pulses a start in the middle of the first frame and once while exposure is high. A shrunken geometry with every region at least one wide lets each column and row class, and every priority combination, appear in a frame of about five hundred cycles.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    REG_DUMMY  = 3'd0,
    REG_DARK   = 3'd1,
    REG_BUFFER = 3'd2,
    REG_CTE    = 3'd3,
    REG_ACTIVE = 3'd4
  } region_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VX1,
    ST_VX2,
    ST_SETTLE,
    ST_HLOW,
    ST_HHIGH
  } seq_state_e;

  function automatic region_e merge_region(region_e row_r, region_e col_r);
    if (col_r == REG_DUMMY)                          return REG_DUMMY;
    else if (col_r == REG_DARK || row_r == REG_DARK) return REG_DARK;
    else if (col_r == REG_CTE || row_r == REG_CTE)   return REG_CTE;
    else if (col_r == REG_BUFFER || row_r == REG_BUFFER) return REG_BUFFER;
    else                                             return REG_ACTIVE;
  endfunction

endpackage

// File: rtl/ccd_phase_timer.sv
module ccd_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         done
);

  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (restart)                       cnt_n = '0;
    else if (en && (cnt_q != limit))   cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign done = en && (cnt_q == limit);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(restart)) |-> (cnt_q <= limit));

endmodule

// File: rtl/ccd_col_map.sv
module ccd_col_map
  import ccd_seq_pkg::*;
#(
  parameter int N_LDUM  = 11,
  parameter int N_LCTE  = 1,
  parameter int N_LDARK = 20,
  parameter int N_LBUF  = 9,
  parameter int N_ACT   = 4080,
  parameter int N_TBUF  = 9,
  parameter int N_TDARK = 9,
  parameter int N_TCTE  = 1,
  parameter int N_TGAP  = 3,
  parameter int N_TDUM  = 2,
  parameter int CW      = 13
) (
  input  logic [CW-1:0] col,
  output region_e       region
);

  localparam int E0 = N_LDUM;
  localparam int E1 = E0 + N_LCTE;
  localparam int E2 = E1 + N_LDARK;
  localparam int E3 = E2 + N_LBUF;
  localparam int E4 = E3 + N_ACT;
  localparam int E5 = E4 + N_TBUF;
  localparam int E6 = E5 + N_TDARK;
  localparam int E7 = E6 + N_TCTE;

  int c;
  always_comb begin
    c = int'(col);
    if      (c < E0) region = REG_DUMMY;
    else if (c < E1) region = REG_CTE;
    else if (c < E2) region = REG_DARK;
    else if (c < E3) region = REG_BUFFER;
    else if (c < E4) region = REG_ACTIVE;
    else if (c < E5) region = REG_BUFFER;
    else if (c < E6) region = REG_DARK;
    else if (c < E7) region = REG_CTE;
    else             region = REG_DUMMY;
  end

endmodule

// File: rtl/ccd_row_map.sv
module ccd_row_map
  import ccd_seq_pkg::*;
#(
  parameter int R_LDARK = 20,
  parameter int R_LBUF  = 9,
  parameter int R_ACT   = 5440,
  parameter int R_TBUF  = 9,
  parameter int R_CTE   = 1,
  parameter int R_TDARK = 9,
  parameter int RW      = 13
) (
  input  logic [RW-1:0] row,
  output region_e       region
);

  localparam int E0 = R_LDARK;
  localparam int E1 = E0 + R_LBUF;
  localparam int E2 = E1 + R_ACT;
  localparam int E3 = E2 + R_TBUF;
  localparam int E4 = E3 + R_CTE;

  int r;
  always_comb begin
    r = int'(row);
    if      (r < E0) region = REG_DARK;
    else if (r < E1) region = REG_BUFFER;
    else if (r < E2) region = REG_ACTIVE;
    else if (r < E3) region = REG_BUFFER;
    else if (r < E4) region = REG_CTE;
    else             region = REG_DARK;
  end

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccd_seq_pkg::*;
#(
  parameter int N_LDUM      = 11,
  parameter int N_LCTE      = 1,
  parameter int N_LDARK     = 20,
  parameter int N_LBUF      = 9,
  parameter int N_ACT       = 4080,
  parameter int N_TBUF      = 9,
  parameter int N_TDARK     = 9,
  parameter int N_TCTE      = 1,
  parameter int N_TGAP      = 3,
  parameter int N_TDUM      = 2,
  parameter int R_LDARK     = 20,
  parameter int R_LBUF      = 9,
  parameter int R_ACT       = 5440,
  parameter int R_TBUF      = 9,
  parameter int R_CTE       = 1,
  parameter int R_TDARK     = 9,
  parameter int HALF_DIV    = 2,
  parameter int VPHASE      = 8,
  parameter int SETTLE      = 16,
  parameter int CLK_KHZ     = 50000,
  parameter int MAX_PIX_KHZ = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expose_i,
  input  logic       start_i,
  output logic       v1_o,
  output logic       v2_o,
  output logic       h1_o,
  output logic       h2_o,
  output logic       h1l_o,
  output logic       pix_strobe_o,
  output logic [2:0] pix_region_o,
  output logic       line_start_o,
  output logic       frame_end_o
);

  localparam int NCOL = N_LDUM + N_LCTE + N_LDARK + N_LBUF + N_ACT
                      + N_TBUF + N_TDARK + N_TCTE + N_TGAP + N_TDUM;
  localparam int NROW = R_LDARK + R_LBUF + R_ACT + R_TBUF + R_CTE + R_TDARK;
  localparam int CW   = $clog2(NCOL);
  localparam int RW   = $clog2(NROW);
  localparam int MAXD = (VPHASE > SETTLE) ? ((VPHASE > HALF_DIV) ? VPHASE : HALF_DIV)
                                          : ((SETTLE > HALF_DIV) ? SETTLE : HALF_DIV);
  localparam int TW   = $clog2(MAXD + 1);

  if (CLK_KHZ > MAX_PIX_KHZ * 2 * HALF_DIV) begin : g_rate_bad
    $error("pixel rate above limit: raise HALF_DIV");
  end

  seq_state_e    state_q, state_n;
  logic [CW-1:0] col_q, col_n;
  logic [RW-1:0] row_q, row_n;
  logic [TW-1:0] limit;
  logic          tmr_done, tmr_en, tmr_restart;
  logic          fe_n, strobe_n, ls_n;
  region_e       row_reg, col_reg, reg_n, reg_q;

  assign tmr_en      = (state_q != ST_IDLE);
  assign tmr_restart = (state_n != state_q);

  always_comb begin
    case (state_q)
      ST_VX1, ST_VX2:   limit = TW'(VPHASE - 1);
      ST_SETTLE:        limit = TW'(SETTLE - 1);
      ST_HLOW, ST_HHIGH: limit = TW'(HALF_DIV - 1);
      default:          limit = '0;
    endcase
  end

  ccd_phase_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .restart(tmr_restart),
    .limit(limit), .done(tmr_done)
  );

  ccd_col_map #(
    .N_LDUM(N_LDUM), .N_LCTE(N_LCTE), .N_LDARK(N_LDARK), .N_LBUF(N_LBUF),
    .N_ACT(N_ACT), .N_TBUF(N_TBUF), .N_TDARK(N_TDARK), .N_TCTE(N_TCTE),
    .N_TGAP(N_TGAP), .N_TDUM(N_TDUM), .CW(CW)
  ) u_colmap (.col(col_n), .region(col_reg));

  ccd_row_map #(
    .R_LDARK(R_LDARK), .R_LBUF(R_LBUF), .R_ACT(R_ACT), .R_TBUF(R_TBUF),
    .R_CTE(R_CTE), .R_TDARK(R_TDARK), .RW(RW)
  ) u_rowmap (.row(row_n), .region(row_reg));

  // next-state process
  always_comb begin
    state_n = state_q;
    col_n   = col_q;
    row_n   = row_q;
    fe_n    = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i && !expose_i) begin
        state_n = ST_VX1;
        row_n   = '0;
      end
      ST_VX1:    if (tmr_done) state_n = ST_VX2;
      ST_VX2:    if (tmr_done) state_n = ST_SETTLE;
      ST_SETTLE: if (tmr_done) begin
        state_n = ST_HLOW;
        col_n   = '0;
      end
      ST_HLOW:   if (tmr_done) state_n = ST_HHIGH;
      ST_HHIGH:  if (tmr_done) begin
        if (col_q == CW'(NCOL - 1)) begin
          if (row_q == RW'(NROW - 1)) begin
            state_n = ST_IDLE;
            fe_n    = 1'b1;
          end else begin
            state_n = ST_VX1;
            row_n   = row_q + 1'b1;
          end
        end else begin
          state_n = ST_HLOW;
          col_n   = col_q + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign strobe_n = (state_n == ST_HLOW) && (state_q != ST_HLOW);
  assign ls_n     = strobe_n && (col_n == '0);
  assign reg_n    = merge_region(row_reg, col_reg);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      col_q        <= '0;
      row_q        <= '0;
      v1_o         <= 1'b0;
      v2_o         <= 1'b0;
      h1_o         <= 1'b1;
      h2_o         <= 1'b0;
      h1l_o        <= 1'b1;
      pix_strobe_o <= 1'b0;
      line_start_o <= 1'b0;
      frame_end_o  <= 1'b0;
      reg_q        <= REG_DUMMY;
    end else begin
      state_q      <= state_n;
      col_q        <= col_n;
      row_q        <= row_n;
      v1_o         <= (state_n == ST_VX1);
      v2_o         <= (state_n == ST_VX2);
      h1_o         <= (state_n != ST_HLOW);
      h2_o         <= (state_n == ST_HLOW);
      h1l_o        <= (state_n != ST_HLOW);
      pix_strobe_o <= strobe_n;
      line_start_o <= ls_n;
      frame_end_o  <= fe_n;
      if (strobe_n) reg_q <= reg_n;
    end
  end

  assign pix_region_o = reg_q;

  p_vexcl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(v1_o && v2_o));
  p_h1_at_vfall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(v2_o) |-> h1_o);
  p_hcomp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    h1_o != h2_o);
  p_strobe_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe_o |-> $fell(h1_o));
  p_ls_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |-> pix_strobe_o);
  p_fe_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |-> (!v1_o && !v2_o && h1_o && !pix_strobe_o));
  p_expose_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && expose_i) |=> !v1_o);

endmodule

// File: tb/ccd_readout_seq_bench.sv
module ccd_readout_seq_bench;

  localparam int LD = 2, LC = 1, LK = 2, LB = 1, AC = 3, TB = 1, TK = 1, TC = 1, TG = 1, TD = 1;
  localparam int RK = 2, RB = 1, RA = 2, RTB = 1, RC = 1, RTK = 1;
  localparam int HALF = 2, VPH = 3, SET = 4;
  localparam int NC = LD + LC + LK + LB + AC + TB + TK + TC + TG + TD;
  localparam int NR = RK + RB + RA + RTB + RC + RTK;

  logic clk = 1'b0;
  logic rst_n, expose, start;
  logic v1, v2, h1, h2, h1l, strb, ls, fe;
  logic [2:0] region;

  always #10 clk = ~clk;

  ccd_readout_seq #(
    .N_LDUM(LD), .N_LCTE(LC), .N_LDARK(LK), .N_LBUF(LB), .N_ACT(AC),
    .N_TBUF(TB), .N_TDARK(TK), .N_TCTE(TC), .N_TGAP(TG), .N_TDUM(TD),
    .R_LDARK(RK), .R_LBUF(RB), .R_ACT(RA), .R_TBUF(RTB), .R_CTE(RC), .R_TDARK(RTK),
    .HALF_DIV(HALF), .VPHASE(VPH), .SETTLE(SET)
  ) u_ccd_readout_seq (
    .clk(clk), .rst_n(rst_n), .expose_i(expose), .start_i(start),
    .v1_o(v1), .v2_o(v2), .h1_o(h1), .h2_o(h2), .h1l_o(h1l),
    .pix_strobe_o(strb), .pix_region_o(region), .line_start_o(ls), .frame_end_o(fe)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural region map: 0 dummy 1 dark 2 buffer 3 monitor 4 active
  function automatic int col_cls(int c);
    int sz[10] = '{LD, LC, LK, LB, AC, TB, TK, TC, TG, TD};
    int cl[10] = '{0, 3, 1, 2, 4, 2, 1, 3, 0, 0};
    int acc = 0;
    for (int g = 0; g < 10; g++) begin
      acc += sz[g];
      if (c < acc) return cl[g];
    end
    return 0;
  endfunction

  function automatic int row_cls(int r);
    int sz[6] = '{RK, RB, RA, RTB, RC, RTK};
    int cl[6] = '{1, 2, 4, 2, 3, 1};
    int acc = 0;
    for (int g = 0; g < 6; g++) begin
      acc += sz[g];
      if (r < acc) return cl[g];
    end
    return 1;
  endfunction

  function automatic int tag(int r, int c);
    int a = row_cls(r), b = col_cls(c);
    if (b == 0) return 0;
    if (a == 1 || b == 1) return 1;
    if (a == 3 || b == 3) return 3;
    if (a == 2 || b == 2) return 2;
    return 4;
  endfunction

  // word: {v1,v2,h1,h2,strb,ls,fe,region[2:0]}
  function automatic logic [9:0] w(bit a, bit b, bit c, bit d, bit s, bit l, bit f, int g);
    return {a, b, c, d, s, l, f, 3'(g)};
  endfunction

  logic [9:0] expq[$];
  logic [9:0] cur;
  logic       busy_model;

  task automatic fill_frame();
    for (int r = 0; r < NR; r++) begin
      for (int k = 0; k < VPH; k++) expq.push_back(w(1, 0, 1, 0, 0, 0, 0, 0));
      for (int k = 0; k < VPH; k++) expq.push_back(w(0, 1, 1, 0, 0, 0, 0, 0));
      for (int k = 0; k < SET; k++) expq.push_back(w(0, 0, 1, 0, 0, 0, 0, 0));
      for (int c = 0; c < NC; c++) begin
        for (int k = 0; k < HALF; k++)
          expq.push_back(w(0, 0, 0, 1, k == 0, (k == 0) && (c == 0), 0, tag(r, c)));
        for (int k = 0; k < HALF; k++) expq.push_back(w(0, 0, 1, 0, 0, 0, 0, 0));
      end
    end
    expq.push_back(w(0, 0, 1, 0, 0, 0, 1, 0));
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      expq.delete();
      cur <= w(0, 0, 1, 0, 0, 0, 0, 0);
    end else begin
      if (expq.size() == 0 && start && !expose) fill_frame();
      if (expq.size() != 0) cur <= expq.pop_front();
      else                  cur <= w(0, 0, 1, 0, 0, 0, 0, 0);
    end
  end

  assign busy_model = (expq.size() != 0);

  int nstrb = 0, nact = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!busy_model && !cur[3]) begin
        chk("R1 rest v1/v2", {v1, v2}, 2'b00);
        chk("R1 rest h1/h2/strobe", {h1, h2, strb}, 3'b100);
      end else begin
        chk("R3 v1", v1, cur[9]);
        chk("R3 v2 / R4 settle", v2, cur[8]);
        chk("R5 h1", h1, cur[7]);
        chk("R5 h2", h2, cur[6]);
        chk("R6 strobe", strb, cur[5]);
        chk("R9 line_start", ls, cur[4]);
        chk("R10 frame_end", fe, cur[3]);
        if (cur[5]) chk("R7 R8 region tag", region, cur[2:0]);
      end
      chk("R5 h1l follows h1", h1l, h1);
      if (strb) begin
        nstrb++;
        if (region == 3'd4) nact++;
      end
      if (fe) begin
        chk("R6 strobes per frame", nstrb, NC * NR);
        chk("R8 active tags per frame", nact, AC * RA);
        nstrb = 0;
        nact  = 0;
      end
    end
  end

  initial begin
    rst_n = 1'b0; expose = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset v1", v1, 1'b0);
    chk("R1 reset h1", h1, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2: start while exposing is ignored
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R2 no readout under exposure", v1, 1'b0);
    expose = 1'b0;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (120) @(negedge clk);
    // R2: start mid-frame is ignored
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fe) @(negedge clk);
    // R10: back-to-back start in the frame_end cycle
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 back-to-back start", v1, 1'b1);
    @(negedge clk);
    while (!fe) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R1 rest after frame", {v1, v2, h1, h2}, 4'b0010);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule